// File: doc/BRIEF.md
# SECDED Partial-Write Merger for a 72-bit Memory Word

This block sits between a 64-bit requester bus and a memory whose every word is 72 bits wide: 64 data bits plus 8 check bits. The memory is never written with a byte mask. Every access to it moves the whole word.

A four-beat burst write takes one data beat per cycle. Each beat is encoded on the way out and stored at full width. A single-beat write carries 8 byte enables and becomes a short sequence:

1. read the stored word;
2. correct it;
3. replace the enabled bytes;
4. re-encode the result;
5. write the full word back.

Reads always fetch whole words. A single-bit error is repaired before the data is returned. A double-bit error is flagged on the response.

Requests marked for the boot ROM region skip the code path entirely. A ROM read is forwarded to a separate 64-bit read port and its data is returned untouched. A ROM write is accepted and dropped.

Corrected errors are counted in a saturating counter, and the last syndrome is kept. Uncorrectable errors set a sticky flag and record the word address.

Top module: `ecc_rmw_merger`

## Requirements
- R1: After reset the block reports `req_ready`=1, `ce_count`=0 and `err_flag`=0, and raises neither `mem_req` nor `rom_req`.
- R2: A burst write (`req_write`=1, `req_burst`=1, `req_rom`=0) issues exactly BURST_LEN full-width memory writes, one per accepted `wd_data` beat. The writes go to `req_addr`, `req_addr`+1, … in order. Bits [63:0] of each stored word equal that beat's data.
- R3: A read issues one full-width memory read per beat, with at most one read outstanding. A burst read returns BURST_LEN responses from consecutive addresses in order. A single read returns exactly one response.
- R4: When exactly one of the 72 stored bits is flipped, the read response carries the original 64-bit data with `rsp_err`=0.
- R5: A corrected read latches `ce_syndrome`:
  - a flipped data bit k gives the k-th (counting from 0) integer of at least 3 that is not a power of two;
  - a flipped stored bit 64+j, for j from 0 to 6, gives 2^j;
  - a flipped stored bit 71 gives 0.

  Each corrected read also increments `ce_count`, which saturates at 2^CNT_W-1.
- R6: When exactly two stored bits are flipped, the read response has `rsp_err`=1. `err_flag` becomes 1 and stays 1, and `err_addr` takes the word address. `ce_count` does not change.
- R7: A single-beat SDRAM write issues exactly one read and then exactly one write, both to `req_addr`. For each byte b, the stored byte (bits 8b+7:8b) becomes `req_wdata` byte b when `req_be[b]`=1. Otherwise it keeps its old corrected value.
- R8: If the read of a single-beat write finds a double-bit error, no memory write is issued. `err_flag` and `err_addr` are latched, and the stored word is left unchanged.
- R9: If the read of a single-beat write finds a single-bit error, the merge uses the corrected data. The word written back then reads with no error.
- R10: A ROM read (`req_rom`=1, `req_write`=0) makes one `rom_req` and no memory access. It returns `rom_rdata` unaltered with `rsp_err`=0, and leaves `ce_count` unchanged.
- R11: A ROM write (`req_rom`=1, `req_write`=1) is accepted and causes no memory and no ROM access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle; a request is taken this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_burst | input | 1 | 1 = BURST_LEN beats, 0 = single beat |
| req_rom | input | 1 | 1 = ROM region, bypasses the code path |
| req_addr | input | ADDR_W | Word address |
| req_be | input | 8 | Byte enables for a single-beat write |
| req_wdata | input | 64 | Data for a single-beat write |
| wd_valid | input | 1 | Burst write beat present |
| wd_ready | output | 1 | Burst write beat taken |
| wd_data | input | 64 | Burst write beat data |
| rsp_valid | output | 1 | Read response beat |
| rsp_data | output | 64 | Corrected read data or ROM data |
| rsp_err | output | 1 | Uncorrectable error on this beat |
| mem_req | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Memory access is a write |
| mem_addr | output | ADDR_W | Memory word address |
| mem_wdata | output | 72 | Encoded word to store |
| mem_rvalid | input | 1 | Memory read data present |
| mem_rdata | input | 72 | Stored word read back |
| rom_req | output | 1 | ROM read this cycle |
| rom_addr | output | ADDR_W | ROM word address |
| rom_rvalid | input | 1 | ROM data present |
| rom_rdata | input | 64 | ROM data |
| err_flag | output | 1 | Sticky uncorrectable-error flag |
| err_addr | output | ADDR_W | Address of the last uncorrectable word |
| ce_count | output | CNT_W | Saturating corrected-error count |
| ce_syndrome | output | 7 | Syndrome of the last corrected word |

## Verification
Every one of the 72 stored bit positions is flipped in turn and read back.

- This separates correct repair from a decoder that only repairs data bits.
- The latched syndrome distinguishes a check-bit flip from a data-bit flip, and from a flip of the overall parity bit.
- A sweep over 72 pairs of flipped bits covers pairs inside the data, inside the check bits and across both, and must always be reported as uncorrectable.

Single-beat writes are tried with full, empty, single-byte, nibble-aligned and alternating byte-enable patterns. These show whether each byte lane picks the right source independently.

Partial writes over a word with one injected error and over a word with two injected errors separate merging with corrected data from merging with raw data, and a completed write-back from an aborted one.

// File: rtl/ecc_rmw_pkg.sv
package ecc_rmw_pkg;

   localparam int DW      = 64;
   localparam int HW      = 7;
   localparam int CW      = HW + 1;
   localparam int WW      = DW + CW;
   localparam int NBYTE   = DW / 8;
   localparam int LASTPOS = DW + HW;

   typedef enum logic [2:0] {
      S_IDLE,
      S_RD_REQ,
      S_RD_WAIT,
      S_MRG_WR,
      S_BURST_WR,
      S_ROM_REQ,
      S_ROM_WAIT
   } seq_t;

   // Hamming parity over the data bits: data bits occupy the positions that
   // are not powers of two, starting at 3, in ascending order.
   function automatic logic [HW-1:0] ham_calc(input logic [DW-1:0] d);
      logic [HW-1:0] h;
      int k;
      h = '0;
      k = 0;
      for (int p = 1; p <= LASTPOS; p++) begin
         if ((p & (p - 1)) != 0) begin
            if (d[k]) h = h ^ p[HW-1:0];
            k = k + 1;
         end
      end
      return h;
   endfunction

endpackage

// File: rtl/secded_enc.sv
module secded_enc
   import ecc_rmw_pkg::*;
(
   input  logic [DW-1:0] data_i,
   output logic [WW-1:0] word_o
);
   logic [HW-1:0] ham;

   always_comb begin
      ham    = ham_calc(data_i);
      word_o = {^{data_i, ham}, ham, data_i};
   end
endmodule

// File: rtl/secded_dec.sv
module secded_dec
   import ecc_rmw_pkg::*;
(
   input  logic [WW-1:0] word_i,
   output logic [DW-1:0] data_o,
   output logic [HW-1:0] syn_o,
   output logic          single_o,
   output logic          double_o
);
   logic [DW-1:0] flip;
   logic          odd;

   always_comb begin
      int k;
      syn_o    = ham_calc(word_i[DW-1:0]) ^ word_i[DW+HW-1:DW];
      odd      = ^word_i;
      single_o = odd;
      double_o = !odd && (syn_o != '0);
      flip     = '0;
      k        = 0;
      for (int p = 1; p <= LASTPOS; p++) begin
         if ((p & (p - 1)) != 0) begin
            if (odd && (syn_o == p[HW-1:0])) flip[k] = 1'b1;
            k = k + 1;
         end
      end
      data_o = word_i[DW-1:0] ^ flip;
   end
endmodule

// File: rtl/byte_merge.sv
module byte_merge #(
   parameter int LANES = 8
) (
   input  logic [LANES-1:0]   be_i,
   input  logic [8*LANES-1:0] old_i,
   input  logic [8*LANES-1:0] new_i,
   output logic [8*LANES-1:0] out_o
);
   for (genvar b = 0; b < LANES; b++) begin : g_lane
      assign out_o[8*b +: 8] = be_i[b] ? new_i[8*b +: 8] : old_i[8*b +: 8];
   end
endmodule

// File: rtl/ecc_rmw_merger.sv
module ecc_rmw_merger
   import ecc_rmw_pkg::*;
#(
   parameter int ADDR_W    = 16,
   parameter int BURST_LEN = 4,
   parameter int CNT_W     = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_write,
   input  logic              req_burst,
   input  logic              req_rom,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [7:0]        req_be,
   input  logic [63:0]       req_wdata,
   input  logic              wd_valid,
   output logic              wd_ready,
   input  logic [63:0]       wd_data,
   output logic              rsp_valid,
   output logic [63:0]       rsp_data,
   output logic              rsp_err,
   output logic              mem_req,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [71:0]       mem_wdata,
   input  logic              mem_rvalid,
   input  logic [71:0]       mem_rdata,
   output logic              rom_req,
   output logic [ADDR_W-1:0] rom_addr,
   input  logic              rom_rvalid,
   input  logic [63:0]       rom_rdata,
   output logic              err_flag,
   output logic [ADDR_W-1:0] err_addr,
   output logic [CNT_W-1:0]  ce_count,
   output logic [6:0]        ce_syndrome
);
   localparam int             BEAT_W  = $clog2(BURST_LEN);
   localparam logic [CNT_W-1:0] CNT_MAX = '1;
   localparam logic [BEAT_W-1:0] LAST_B = BEAT_W'(BURST_LEN - 1);

   // elaboration-time parameter checks
   if (BURST_LEN < 2 || (BURST_LEN & (BURST_LEN - 1)) != 0) begin : g_bad_burst
      $error("BURST_LEN must be a power of two of at least 2");
   end
   if (ADDR_W <= BEAT_W) begin : g_bad_addr
      $error("ADDR_W too small for the burst length");
   end
   if (CNT_W < 1) begin : g_bad_cnt
      $error("CNT_W must be positive");
   end
   if (DW != 64 || NBYTE != 8 || WW != 72 || HW != 7) begin : g_bad_code
      $error("code layout does not match the 64+8 port widths");
   end

   seq_t              st_q;
   logic [ADDR_W-1:0] base_q;
   logic [BEAT_W-1:0] beat_q;
   logic [BEAT_W-1:0] last_q;
   logic              rmw_q;
   logic [NBYTE-1:0]  be_q;
   logic [DW-1:0]     wdata_q;
   logic [DW-1:0]     merged_q;

   logic [ADDR_W-1:0] cur_addr;
   logic [DW-1:0]     enc_in;
   logic [WW-1:0]     enc_word;
   logic [DW-1:0]     dec_data;
   logic [HW-1:0]     dec_syn;
   logic              dec_single;
   logic              dec_double;
   logic [DW-1:0]     merge_out;
   logic              rd_beat;

   assign cur_addr = base_q + ADDR_W'(beat_q);
   assign enc_in   = (st_q == S_BURST_WR) ? wd_data : merged_q;
   assign rd_beat  = (st_q == S_RD_WAIT) && mem_rvalid;

   secded_enc u_enc (
      .data_i (enc_in),
      .word_o (enc_word)
   );

   secded_dec u_dec (
      .word_i   (mem_rdata),
      .data_o   (dec_data),
      .syn_o    (dec_syn),
      .single_o (dec_single),
      .double_o (dec_double)
   );

   byte_merge #(.LANES(NBYTE)) u_merge (
      .be_i  (be_q),
      .old_i (dec_data),
      .new_i (wdata_q),
      .out_o (merge_out)
   );

   // request-side outputs
   assign req_ready = (st_q == S_IDLE);
   assign wd_ready  = (st_q == S_BURST_WR);
   assign mem_req   = (st_q == S_RD_REQ) || (st_q == S_MRG_WR) ||
                      ((st_q == S_BURST_WR) && wd_valid);
   assign mem_we    = mem_req && ((st_q == S_MRG_WR) || (st_q == S_BURST_WR));
   assign mem_addr  = cur_addr;
   assign mem_wdata = enc_word;
   assign rom_req   = (st_q == S_ROM_REQ);
   assign rom_addr  = base_q;

   // response-side outputs
   assign rsp_valid = (rd_beat && !rmw_q) || ((st_q == S_ROM_WAIT) && rom_rvalid);
   assign rsp_data  = (st_q == S_ROM_WAIT) ? rom_rdata : dec_data;
   assign rsp_err   = rd_beat && dec_double;

   // sequencer
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q     <= S_IDLE;
         base_q   <= '0;
         beat_q   <= '0;
         last_q   <= '0;
         rmw_q    <= 1'b0;
         be_q     <= '0;
         wdata_q  <= '0;
         merged_q <= '0;
      end else begin
         unique case (st_q)
            S_IDLE: begin
               if (req_valid) begin
                  base_q  <= req_addr;
                  beat_q  <= '0;
                  be_q    <= req_be;
                  wdata_q <= req_wdata;
                  rmw_q   <= req_write;
                  last_q  <= (req_burst && !req_write) ? LAST_B : '0;
                  if (req_rom) begin
                     st_q <= req_write ? S_IDLE : S_ROM_REQ;
                  end else if (req_write && req_burst) begin
                     st_q <= S_BURST_WR;
                  end else begin
                     st_q <= S_RD_REQ;
                  end
               end
            end
            S_RD_REQ: st_q <= S_RD_WAIT;
            S_RD_WAIT: begin
               if (mem_rvalid) begin
                  if (rmw_q) begin
                     merged_q <= merge_out;
                     st_q     <= dec_double ? S_IDLE : S_MRG_WR;
                  end else if (beat_q == last_q) begin
                     st_q <= S_IDLE;
                  end else begin
                     beat_q <= beat_q + 1'b1;
                     st_q   <= S_RD_REQ;
                  end
               end
            end
            S_MRG_WR: st_q <= S_IDLE;
            S_BURST_WR: begin
               if (wd_valid) begin
                  if (beat_q == LAST_B) st_q <= S_IDLE;
                  else beat_q <= beat_q + 1'b1;
               end
            end
            S_ROM_REQ: st_q <= S_ROM_WAIT;
            S_ROM_WAIT: begin
               if (rom_rvalid) st_q <= S_IDLE;
            end
            default: st_q <= S_IDLE;
         endcase
      end
   end

   // error bookkeeping
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         err_flag    <= 1'b0;
         err_addr    <= '0;
         ce_count    <= '0;
         ce_syndrome <= '0;
      end else if (rd_beat) begin
         if (dec_single) begin
            ce_syndrome <= dec_syn;
            if (ce_count != CNT_MAX) ce_count <= ce_count + 1'b1;
         end
         if (dec_double) begin
            err_flag <= 1'b1;
            err_addr <= cur_addr;
         end
      end
   end
endmodule

// File: rtl/ecc_rmw_merger_chk.sv
module ecc_rmw_merger_chk #(
   parameter int CNT_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             req_ready,
   input logic             rsp_valid,
   input logic             mem_req,
   input logic             mem_we,
   input logic             wd_ready,
   input logic             wd_valid,
   input logic             rom_req,
   input logic             err_flag,
   input logic [CNT_W-1:0] ce_count
);
   localparam logic [CNT_W-1:0] TOP = '1;

   // R3
   one_rd_outstanding_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_we) |=> !mem_req);

   // R3
   rsp_only_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> !req_ready);

   // R2
   burst_beat_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_we && wd_ready) |-> wd_valid);

   // R10
   rom_no_mem_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rom_req |-> !mem_req);

   // R6
   err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      err_flag |=> err_flag);

   // R5
   ce_saturate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ce_count == TOP) |=> (ce_count == TOP));

   // R5
   ce_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ce_count != TOP) |=> (ce_count == $past(ce_count) ||
                             ce_count == $past(ce_count) + 1'b1));
endmodule

bind ecc_rmw_merger ecc_rmw_merger_chk #(.CNT_W(CNT_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_ready (req_ready),
   .rsp_valid (rsp_valid),
   .mem_req   (mem_req),
   .mem_we    (mem_we),
   .wd_ready  (wd_ready),
   .wd_valid  (wd_valid),
   .rom_req   (rom_req),
   .err_flag  (err_flag),
   .ce_count  (ce_count)
);

// File: tb/ecc_rmw_merger_bench.sv
module ecc_rmw_merger_bench;
   localparam int CLK_PERIOD = 10;
   localparam int AW = 16;
   localparam int CW = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0, req_write = 1'b0, req_burst = 1'b0, req_rom = 1'b0;
   logic [AW-1:0] req_addr = '0;
   logic [7:0]    req_be = '0;
   logic [63:0]   req_wdata = '0;
   logic          wd_valid = 1'b0;
   logic [63:0]   wd_data = '0;
   logic          req_ready, wd_ready, rsp_valid, rsp_err;
   logic [63:0]   rsp_data;
   logic          mem_req, mem_we, rom_req;
   logic [AW-1:0] mem_addr, rom_addr, err_addr;
   logic [71:0]   mem_wdata;
   logic          mem_rvalid = 1'b0, rom_rvalid = 1'b0;
   logic [71:0]   mem_rdata = '0;
   logic [63:0]   rom_rdata = '0;
   logic          err_flag;
   logic [CW-1:0] ce_count;
   logic [6:0]    ce_syndrome;

   always #(CLK_PERIOD/2) clk = ~clk;

   ecc_rmw_merger #(.ADDR_W(AW), .BURST_LEN(4), .CNT_W(CW)) u_ecc_rmw_merger (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_write(req_write), .req_burst(req_burst), .req_rom(req_rom),
      .req_addr(req_addr), .req_be(req_be), .req_wdata(req_wdata),
      .wd_valid(wd_valid), .wd_ready(wd_ready), .wd_data(wd_data),
      .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_err(rsp_err),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
      .rom_req(rom_req), .rom_addr(rom_addr), .rom_rvalid(rom_rvalid), .rom_rdata(rom_rdata),
      .err_flag(err_flag), .err_addr(err_addr), .ce_count(ce_count), .ce_syndrome(ce_syndrome)
   );

   // memory and ROM models
   logic [71:0] mem [0:15];
   initial for (int i = 0; i < 16; i++) mem[i] = '0;

   always @(posedge clk) begin
      mem_rvalid <= rst_n && mem_req && !mem_we;
      if (mem_req && !mem_we) mem_rdata <= mem[mem_addr[3:0]];
      if (mem_req && mem_we) mem[mem_addr[3:0]] <= mem_wdata;
      rom_rvalid <= rst_n && rom_req;
      if (rom_req) rom_rdata <= 64'hFACE_0000_0000_0000 | 64'(rom_addr);
   end

   // port monitor, sampled mid-cycle
   int n_rsp, n_wr, n_rd, n_rom;
   logic [63:0] rd_d [0:7];
   logic        rd_e [0:7];
   logic [AW-1:0] wr_a [0:7];
   logic [71:0]   wr_d [0:7];

   always @(negedge clk) begin
      if (rst_n) begin
         if (rsp_valid) begin
            if (n_rsp < 8) begin rd_d[n_rsp] = rsp_data; rd_e[n_rsp] = rsp_err; end
            n_rsp = n_rsp + 1;
         end
         if (mem_req && mem_we) begin
            if (n_wr < 8) begin wr_a[n_wr] = mem_addr; wr_d[n_wr] = mem_wdata; end
            n_wr = n_wr + 1;
         end
         if (mem_req && !mem_we) n_rd = n_rd + 1;
         if (rom_req) n_rom = n_rom + 1;
      end
   end

   int n_chk = 0, n_bad = 0;

   task automatic chk(input string tag, input logic [71:0] act, input logic [71:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic clr();
      n_rsp = 0; n_wr = 0; n_rd = 0; n_rom = 0;
   endtask

   task automatic start(input logic w, input logic b, input logic r,
                        input logic [AW-1:0] a, input logic [7:0] be, input logic [63:0] d);
      while (!req_ready) tick();
      req_valid = 1'b1; req_write = w; req_burst = b; req_rom = r;
      req_addr = a; req_be = be; req_wdata = d;
      tick();
      req_valid = 1'b0;
   endtask

   task automatic wait_idle();
      while (!req_ready) tick();
      tick();
   endtask

   task automatic wr1(input logic [AW-1:0] a, input logic [7:0] be, input logic [63:0] d);
      clr();
      start(1'b1, 1'b0, 1'b0, a, be, d);
      wait_idle();
   endtask

   task automatic rd(input logic [AW-1:0] a, input logic b);
      clr();
      start(1'b0, b, 1'b0, a, 8'h00, 64'h0);
      wait_idle();
   endtask

   function automatic logic [63:0] merge(input logic [63:0] o, input logic [63:0] n,
                                         input logic [7:0] be);
      logic [63:0] r;
      for (int b = 0; b < 8; b++) r[8*b +: 8] = be[b] ? n[8*b +: 8] : o[8*b +: 8];
      return r;
   endfunction

   function automatic int pos_of_data(input int k);
      int c;
      c = 0;
      for (int p = 3; p < 128; p++) begin
         if ((p & (p - 1)) != 0) begin
            if (c == k) return p;
            c++;
         end
      end
      return -1;
   endfunction

   function automatic logic [6:0] exp_syn(input int i);
      if (i < 64) return 7'(pos_of_data(i));
      if (i < 71) return 7'(1 << (i - 64));
      return 7'd0;
   endfunction

   function automatic logic [63:0] bdata(input int b);
      return 64'h0123_4567_89AB_CDEF ^ {8{8'(b * 17 + 3)}};
   endfunction

   // watchdog
   initial begin
      repeat (150000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin
      logic [63:0] cur, a13, exp13;
      logic [7:0]  bes [0:7];
      int          cnt;
      logic [71:0] keep;
      bes[0] = 8'hFF; bes[1] = 8'h00; bes[2] = 8'h01; bes[3] = 8'h80;
      bes[4] = 8'h0F; bes[5] = 8'hF0; bes[6] = 8'h5A; bes[7] = 8'hA5;
      clr();

      repeat (3) tick();
      @(posedge clk); #1 rst_n = 1'b1;
      #2;
      // R1 reset state
      chk("R1 req_ready", 72'(req_ready), 72'd1);
      chk("R1 ce_count", 72'(ce_count), 72'd0);
      chk("R1 err_flag", 72'(err_flag), 72'd0);
      chk("R1 mem_req", 72'(mem_req), 72'd0);
      chk("R1 rom_req", 72'(rom_req), 72'd0);
      tick();

      // R2 burst write at 8..11
      clr();
      start(1'b1, 1'b1, 1'b0, 16'd8, 8'h00, 64'h0);
      for (int b = 0; b < 4; b++) begin
         wd_valid = 1'b1; wd_data = bdata(b);
         tick();
      end
      wd_valid = 1'b0;
      wait_idle();
      chk("R2 write count", 72'(n_wr), 72'd4);
      chk("R2 read count", 72'(n_rd), 72'd0);
      for (int b = 0; b < 4; b++) begin
         chk("R2 write addr", 72'(wr_a[b]), 72'(8 + b));
         chk("R2 write data", 72'(wr_d[b][63:0]), 72'(bdata(b)));
      end

      // R3 burst read and single read
      rd(16'd8, 1'b1);
      chk("R3 burst rsp count", 72'(n_rsp), 72'd4);
      chk("R3 burst read count", 72'(n_rd), 72'd4);
      for (int b = 0; b < 4; b++) begin
         chk("R3 burst data", 72'(rd_d[b]), 72'(bdata(b)));
         chk("R3 burst err", 72'(rd_e[b]), 72'd0);
      end
      rd(16'd9, 1'b0);
      chk("R3 single rsp count", 72'(n_rsp), 72'd1);
      chk("R3 single data", 72'(rd_d[0]), 72'(bdata(1)));

      // R7 byte-enable sweep at address 10
      cur = bdata(2);
      for (int t = 0; t < 8; t++) begin
         logic [63:0] nd;
         nd = 64'hDEAD_BEEF_0BAD_F00D ^ {8{8'(t * 29)}};
         wr1(16'd10, bes[t], nd);
         cur = merge(cur, nd, bes[t]);
         chk("R7 rmw read count", 72'(n_rd), 72'd1);
         chk("R7 rmw write count", 72'(n_wr), 72'd1);
         chk("R7 rmw write addr", 72'(wr_a[0]), 72'd10);
         rd(16'd10, 1'b0);
         chk("R7 merged data", 72'(rd_d[0]), 72'(cur));
      end

      // R9 single-bit error under a partial write at address 13
      a13 = 64'h1111_2222_3333_4444;
      wr1(16'd13, 8'hFF, a13);
      mem[13] = mem[13] ^ (72'd1 << 5);
      wr1(16'd13, 8'h0F, 64'h9999_8888_7777_6666);
      exp13 = merge(a13, 64'h9999_8888_7777_6666, 8'h0F);
      chk("R9 write issued", 72'(n_wr), 72'd1);
      chk("R9 ce_count after rmw", 72'(ce_count), 72'd1);
      chk("R9 syndrome", 72'(ce_syndrome), 72'(exp_syn(5)));
      rd(16'd13, 1'b0);
      chk("R9 merged data", 72'(rd_d[0]), 72'(exp13));
      chk("R9 clean write-back", 72'(ce_count), 72'd1);

      // R4/R5 single-bit sweep over all 72 stored bits at address 10
      cnt = 1;
      for (int i = 0; i < 72; i++) begin
         mem[10] = mem[10] ^ (72'd1 << i);
         rd(16'd10, 1'b0);
         mem[10] = mem[10] ^ (72'd1 << i);
         if (cnt < 15) cnt++;
         chk("R4 corrected data", 72'(rd_d[0]), 72'(cur));
         chk("R4 no err", 72'(rd_e[0]), 72'd0);
         chk("R5 syndrome", 72'(ce_syndrome), 72'(exp_syn(i)));
         chk("R5 ce_count", 72'(ce_count), 72'(cnt));
      end

      // R6 double-bit sweep
      for (int i = 0; i < 72; i++) begin
         int j;
         j = (i + 1 + (i % 7)) % 72;
         mem[10] = mem[10] ^ (72'd1 << i) ^ (72'd1 << j);
         rd(16'd10, 1'b0);
         mem[10] = mem[10] ^ (72'd1 << i) ^ (72'd1 << j);
         chk("R6 rsp_err", 72'(rd_e[0]), 72'd1);
         chk("R6 err_flag", 72'(err_flag), 72'd1);
         chk("R6 err_addr", 72'(err_addr), 72'd10);
         chk("R6 ce_count held", 72'(ce_count), 72'd15);
      end

      // R8 double-bit error under a partial write at address 12
      mem[12] = mem[12] ^ (72'd1 << 3) ^ (72'd1 << 40);
      keep = mem[12];
      wr1(16'd12, 8'hFF, 64'h5555_AAAA_5555_AAAA);
      chk("R8 read issued", 72'(n_rd), 72'd1);
      chk("R8 no write", 72'(n_wr), 72'd0);
      chk("R8 err_addr", 72'(err_addr), 72'd12);
      chk("R8 err_flag", 72'(err_flag), 72'd1);
      chk("R8 word unchanged", mem[12], keep);

      // R10 ROM read bypass
      rd(16'h0033, 1'b0);
      clr();
      start(1'b0, 1'b0, 1'b1, 16'h0033, 8'h00, 64'h0);
      wait_idle();
      chk("R10 rom data", 72'(rd_d[0]), 72'(64'hFACE_0000_0000_0033));
      chk("R10 rom err", 72'(rd_e[0]), 72'd0);
      chk("R10 rom count", 72'(n_rom), 72'd1);
      chk("R10 no mem access", 72'(n_rd + n_wr), 72'd0);
      chk("R10 ce_count", 72'(ce_count), 72'd15);

      // R11 ROM write dropped
      clr();
      start(1'b1, 1'b0, 1'b1, 16'h0005, 8'hFF, 64'h1234);
      repeat (4) tick();
      chk("R11 no access", 72'(n_rd + n_wr + n_rom), 72'd0);
      chk("R11 ready", 72'(req_ready), 72'd1);

      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end
endmodule